// File: doc/BRIEF.md
# Pipelined Sign-Magnitude Floating-Point Adder

This block adds two floating-point operands, each held as a sign bit, an unsigned exponent and a fraction. An operand's value is (-1)^sign × (F / 2^FRAC_W) × 2^E, where F is the fraction field read as an unsigned integer. The block accepts a new operand pair on any cycle that `in_vld` is high. The sum leaves four cycles later with its own valid bit.

The work is split over four register stages. The first stage compares the exponents. It keeps the larger one and the distance between them, and it marks which operand has the smaller exponent. The second stage shifts that operand's fraction right by the distance. It then adds the two magnitudes, or subtracts the smaller from the larger. The third stage counts the leading zeros of the raw sum. The fourth stage normalises the result: it shifts left and lowers the exponent, or it takes a carry by shifting right one place and raising the exponent.

Bits that fall off the right are dropped (truncation). Exponents that would leave their range are clamped. Special values and rounding modes are not handled.

Top module: `fpa_pipe_add`

## Requirements
- R1: Each pair sampled with `in_vld` high gives exactly one result with `out_vld` high, four clock edges later. Results come out in issue order, and a new pair may be issued on every cycle.
- R2: For any inputs, the output sign, exponent and fraction equal the truncated sum that R3 to R8 define.
- R3: The operand with the smaller exponent has its fraction shifted right by the exponent difference, and the bits shifted out are lost. When the exponents are equal, operand A counts as the larger one. A difference of FRAC_W or more makes that operand add nothing.
- R4: When the signs match, the magnitudes are added and the result takes the common sign. If the addition carries out past bit FRAC_W-1, the result fraction is the sum shifted right by one (its LSB dropped), and the exponent rises by one.
- R5: When the signs differ, the smaller aligned magnitude is subtracted from the larger one. The result takes the sign of the operand whose aligned magnitude is larger.
- R6: A nonzero result with no carry is shifted left by its leading-zero count, so that fraction bit FRAC_W-1 is 1 (0.5 ≤ d < 1). Its exponent is lowered by the same count.
- R7: A zero sum comes out as sign 0, exponent 0 and fraction 0.
- R8: When a carry meets the exponent 2^EXP_W-1, the exponent stays at that maximum. When normalisation would take the exponent below 0, the exponent becomes 0 and the fraction is still normalised.
- R9: While `rst_n` is low, `out_vld`, `out_sgn`, `out_exp` and `out_frac` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Operand pair valid |
| a_sgn | input | 1 | Sign of A (1 = negative) |
| a_exp | input | EXP_W | Exponent of A, unsigned |
| a_frac | input | FRAC_W | Fraction of A |
| b_sgn | input | 1 | Sign of B (1 = negative) |
| b_exp | input | EXP_W | Exponent of B, unsigned |
| b_frac | input | FRAC_W | Fraction of B |
| out_vld | output | 1 | Result valid |
| out_sgn | output | 1 | Result sign |
| out_exp | output | EXP_W | Result exponent |
| out_frac | output | FRAC_W | Normalised result fraction |

## Verification
The last stage can meet an adder carry and the top of the exponent range in the same cycle. Same-sign operands at the maximum exponent provoke this, and the bench expects a halved fraction with the exponent held at its maximum. A large cancellation can likewise drive the left-shift count past the exponent, and the bench expects a normalised fraction with exponent 0. These cases run back to back, mixed with random operand pairs. A scoreboard compares every result, and its arrival cycle, with values computed from the requirements.

// File: rtl/fpa_pkg.sv
package fpa_pkg;
   // Effective magnitude operation, chosen from the two operand signs
   typedef enum logic {
      MAG_ADD = 1'b0,
      MAG_SUB = 1'b1
   } mag_op_e;
endpackage

// File: rtl/fpa_s1_align.sv
module fpa_s1_align
   import fpa_pkg::*;
#(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 16,
   parameter int SH_W   = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_vld,
   input  logic              a_sgn,
   input  logic [EXP_W-1:0]  a_exp,
   input  logic [FRAC_W-1:0] a_frac,
   input  logic              b_sgn,
   input  logic [EXP_W-1:0]  b_exp,
   input  logic [FRAC_W-1:0] b_frac,
   output logic              s1_vld,
   output logic [EXP_W-1:0]  s1_exp,
   output logic [SH_W-1:0]   s1_shamt,
   output mag_op_e           s1_op,
   output logic              s1_big_sgn,
   output logic [FRAC_W-1:0] s1_big_frac,
   output logic              s1_sml_sgn,
   output logic [FRAC_W-1:0] s1_sml_frac
);
   localparam logic [EXP_W:0] FW_LIM = (EXP_W+1)'(FRAC_W);

   logic             a_ge;
   logic [EXP_W-1:0] diff;
   logic [SH_W-1:0]  shamt_c;

   always_comb begin
      a_ge    = (a_exp >= b_exp);
      diff    = a_ge ? (a_exp - b_exp) : (b_exp - a_exp);
      shamt_c = ({1'b0, diff} >= FW_LIM) ? SH_W'(FRAC_W) : diff[SH_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_vld      <= 1'b0;
         s1_exp      <= '0;
         s1_shamt    <= '0;
         s1_op       <= MAG_ADD;
         s1_big_sgn  <= 1'b0;
         s1_big_frac <= '0;
         s1_sml_sgn  <= 1'b0;
         s1_sml_frac <= '0;
      end else begin
         s1_vld      <= in_vld;
         s1_exp      <= a_ge ? a_exp : b_exp;
         s1_shamt    <= shamt_c;
         s1_op       <= (a_sgn == b_sgn) ? MAG_ADD : MAG_SUB;
         s1_big_sgn  <= a_ge ? a_sgn  : b_sgn;
         s1_big_frac <= a_ge ? a_frac : b_frac;
         s1_sml_sgn  <= a_ge ? b_sgn  : a_sgn;
         s1_sml_frac <= a_ge ? b_frac : a_frac;
      end
   end

   // R3
   max_exp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |=> (s1_exp >= $past(a_exp)) && (s1_exp >= $past(b_exp)));
endmodule

// File: rtl/fpa_s2_add.sv
module fpa_s2_add
   import fpa_pkg::*;
#(
   parameter int EXP_W     = 8,
   parameter int FRAC_W    = 16,
   parameter int SH_W      = 5,
   parameter bit LOG_SHIFT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              s1_vld,
   input  logic [EXP_W-1:0]  s1_exp,
   input  logic [SH_W-1:0]   s1_shamt,
   input  mag_op_e           s1_op,
   input  logic              s1_big_sgn,
   input  logic [FRAC_W-1:0] s1_big_frac,
   input  logic              s1_sml_sgn,
   input  logic [FRAC_W-1:0] s1_sml_frac,
   output logic              s2_vld,
   output logic              s2_sgn,
   output logic [EXP_W-1:0]  s2_exp,
   output logic [FRAC_W:0]   s2_sum
);
   logic [FRAC_W-1:0] aligned;

   generate
      if (LOG_SHIFT) begin : g_log_shift
         logic [FRAC_W-1:0] lvl [SH_W+1];
         assign lvl[0] = s1_sml_frac;
         for (genvar k = 0; k < SH_W; k++) begin : g_lvl
            assign lvl[k+1] = s1_shamt[k] ? (lvl[k] >> (2**k)) : lvl[k];
         end
         assign aligned = lvl[SH_W];
      end else begin : g_op_shift
         assign aligned = s1_sml_frac >> s1_shamt;
      end
   endgenerate

   logic [FRAC_W:0] sum_c;
   logic            sgn_c;

   always_comb begin
      if (s1_op == MAG_ADD) begin
         sum_c = {1'b0, s1_big_frac} + {1'b0, aligned};
         sgn_c = s1_big_sgn;
      end else if (s1_big_frac >= aligned) begin
         sum_c = {1'b0, s1_big_frac - aligned};
         sgn_c = s1_big_sgn;
      end else begin
         sum_c = {1'b0, aligned - s1_big_frac};
         sgn_c = s1_sml_sgn;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s2_vld <= 1'b0;
         s2_sgn <= 1'b0;
         s2_exp <= '0;
         s2_sum <= '0;
      end else begin
         s2_vld <= s1_vld;
         s2_sgn <= sgn_c;
         s2_exp <= s1_exp;
         s2_sum <= sum_c;
      end
   end

   // R5
   sub_no_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_vld && s1_op == MAG_SUB) |=> !s2_sum[FRAC_W]);

   // R3
   far_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_vld && s1_op == MAG_ADD && s1_shamt == SH_W'(FRAC_W))
      |=> s2_sum == {1'b0, $past(s1_big_frac)});
endmodule

// File: rtl/fpa_s3_lzc.sv
module fpa_s3_lzc #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 16,
   parameter int SH_W   = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              s2_vld,
   input  logic              s2_sgn,
   input  logic [EXP_W-1:0]  s2_exp,
   input  logic [FRAC_W:0]   s2_sum,
   output logic              s3_vld,
   output logic              s3_sgn,
   output logic [EXP_W-1:0]  s3_exp,
   output logic [FRAC_W:0]   s3_sum,
   output logic [SH_W-1:0]   s3_lz
);
   // clear_above[i] is 1 when bits FRAC_W-1 down to i of the sum are all 0
   logic [FRAC_W:0] clear_above;
   assign clear_above[FRAC_W] = 1'b1;
   generate
      for (genvar i = FRAC_W-1; i >= 0; i--) begin : g_chain
         assign clear_above[i] = clear_above[i+1] & ~s2_sum[i];
      end
   endgenerate

   logic [SH_W-1:0] lz_c;
   always_comb begin
      lz_c = '0;
      for (int i = 0; i < FRAC_W; i++) begin
         lz_c = lz_c + SH_W'(clear_above[i]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s3_vld <= 1'b0;
         s3_sgn <= 1'b0;
         s3_exp <= '0;
         s3_sum <= '0;
         s3_lz  <= '0;
      end else begin
         s3_vld <= s2_vld;
         s3_sgn <= s2_sgn;
         s3_exp <= s2_exp;
         s3_sum <= s2_sum;
         s3_lz  <= lz_c;
      end
   end
endmodule

// File: rtl/fpa_s4_norm.sv
module fpa_s4_norm #(
   parameter int EXP_W    = 8,
   parameter int FRAC_W   = 16,
   parameter int SH_W     = 5,
   parameter bit SATURATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              s3_vld,
   input  logic              s3_sgn,
   input  logic [EXP_W-1:0]  s3_exp,
   input  logic [FRAC_W:0]   s3_sum,
   input  logic [SH_W-1:0]   s3_lz,
   output logic              out_vld,
   output logic              out_sgn,
   output logic [EXP_W-1:0]  out_exp,
   output logic [FRAC_W-1:0] out_frac
);
   localparam logic [EXP_W-1:0] EXP_MAX = '1;

   logic [EXP_W-1:0] lz_e;
   logic [EXP_W-1:0] exp_up;
   logic [EXP_W-1:0] exp_dn;
   assign lz_e = EXP_W'(s3_lz);

   generate
      if (SATURATE) begin : g_sat
         assign exp_up = (s3_exp == EXP_MAX) ? EXP_MAX : s3_exp + 1'b1;
         assign exp_dn = (s3_exp < lz_e) ? '0 : s3_exp - lz_e;
      end else begin : g_wrap
         assign exp_up = s3_exp + 1'b1;
         assign exp_dn = s3_exp - lz_e;
      end
   endgenerate

   logic              sgn_c;
   logic [EXP_W-1:0]  exp_c;
   logic [FRAC_W-1:0] frac_c;

   always_comb begin
      if (s3_sum == '0) begin
         sgn_c  = 1'b0;
         exp_c  = '0;
         frac_c = '0;
      end else if (s3_sum[FRAC_W]) begin
         sgn_c  = s3_sgn;
         exp_c  = exp_up;
         frac_c = s3_sum[FRAC_W:1];
      end else begin
         sgn_c  = s3_sgn;
         exp_c  = exp_dn;
         frac_c = s3_sum[FRAC_W-1:0] << s3_lz;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_vld  <= 1'b0;
         out_sgn  <= 1'b0;
         out_exp  <= '0;
         out_frac <= '0;
      end else begin
         out_vld  <= s3_vld;
         out_sgn  <= sgn_c;
         out_exp  <= exp_c;
         out_frac <= frac_c;
      end
   end

   // R6
   lz_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (s3_vld && s3_sum[FRAC_W-1:0] != '0)
      |-> ((s3_sum[FRAC_W-1:0] >> (FRAC_W - 1 - int'(s3_lz))) == FRAC_W'(1)));

   // R6
   normalized_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld && out_frac != '0) |-> out_frac[FRAC_W-1]);

   // R7
   zero_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld && out_frac == '0) |-> (!out_sgn && out_exp == '0));

   // R8
   exp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (SATURATE && s3_vld && s3_sum[FRAC_W] && s3_exp == EXP_MAX) |=> out_exp == EXP_MAX);
endmodule

// File: rtl/fpa_pipe_add.sv
module fpa_pipe_add
   import fpa_pkg::*;
#(
   parameter int EXP_W     = 8,
   parameter int FRAC_W    = 16,
   parameter bit LOG_SHIFT = 1'b1,
   parameter bit SATURATE  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_vld,
   input  logic              a_sgn,
   input  logic [EXP_W-1:0]  a_exp,
   input  logic [FRAC_W-1:0] a_frac,
   input  logic              b_sgn,
   input  logic [EXP_W-1:0]  b_exp,
   input  logic [FRAC_W-1:0] b_frac,
   output logic              out_vld,
   output logic              out_sgn,
   output logic [EXP_W-1:0]  out_exp,
   output logic [FRAC_W-1:0] out_frac
);
   localparam int SH_W    = $clog2(FRAC_W + 1);
   localparam int LATENCY = 4;

   generate
      if (FRAC_W < 2) begin : g_bad_frac
         $error("fpa_pipe_add: FRAC_W must be at least 2");
      end
      if (EXP_W < SH_W) begin : g_bad_exp
         $error("fpa_pipe_add: EXP_W must cover the shift count width");
      end
   endgenerate

   logic              s1_vld, s1_big_sgn, s1_sml_sgn;
   logic [EXP_W-1:0]  s1_exp;
   logic [SH_W-1:0]   s1_shamt;
   mag_op_e           s1_op;
   logic [FRAC_W-1:0] s1_big_frac, s1_sml_frac;

   logic              s2_vld, s2_sgn;
   logic [EXP_W-1:0]  s2_exp;
   logic [FRAC_W:0]   s2_sum;

   logic              s3_vld, s3_sgn;
   logic [EXP_W-1:0]  s3_exp;
   logic [FRAC_W:0]   s3_sum;
   logic [SH_W-1:0]   s3_lz;

   fpa_s1_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .SH_W(SH_W)) u_s1 (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld),
      .a_sgn(a_sgn), .a_exp(a_exp), .a_frac(a_frac),
      .b_sgn(b_sgn), .b_exp(b_exp), .b_frac(b_frac),
      .s1_vld(s1_vld), .s1_exp(s1_exp), .s1_shamt(s1_shamt), .s1_op(s1_op),
      .s1_big_sgn(s1_big_sgn), .s1_big_frac(s1_big_frac),
      .s1_sml_sgn(s1_sml_sgn), .s1_sml_frac(s1_sml_frac));

   fpa_s2_add #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .SH_W(SH_W), .LOG_SHIFT(LOG_SHIFT)) u_s2 (
      .clk(clk), .rst_n(rst_n),
      .s1_vld(s1_vld), .s1_exp(s1_exp), .s1_shamt(s1_shamt), .s1_op(s1_op),
      .s1_big_sgn(s1_big_sgn), .s1_big_frac(s1_big_frac),
      .s1_sml_sgn(s1_sml_sgn), .s1_sml_frac(s1_sml_frac),
      .s2_vld(s2_vld), .s2_sgn(s2_sgn), .s2_exp(s2_exp), .s2_sum(s2_sum));

   fpa_s3_lzc #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .SH_W(SH_W)) u_s3 (
      .clk(clk), .rst_n(rst_n),
      .s2_vld(s2_vld), .s2_sgn(s2_sgn), .s2_exp(s2_exp), .s2_sum(s2_sum),
      .s3_vld(s3_vld), .s3_sgn(s3_sgn), .s3_exp(s3_exp), .s3_sum(s3_sum), .s3_lz(s3_lz));

   fpa_s4_norm #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .SH_W(SH_W), .SATURATE(SATURATE)) u_s4 (
      .clk(clk), .rst_n(rst_n),
      .s3_vld(s3_vld), .s3_sgn(s3_sgn), .s3_exp(s3_exp), .s3_sum(s3_sum), .s3_lz(s3_lz),
      .out_vld(out_vld), .out_sgn(out_sgn), .out_exp(out_exp), .out_frac(out_frac));

   // Cycles since reset, held at LATENCY, so the valid check never looks before reset
   logic [2:0] since_rst;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        since_rst <= '0;
      else if (since_rst != 3'(LATENCY)) since_rst <= since_rst + 3'd1;
   end

   // R1
   valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst == 3'(LATENCY)) |-> (out_vld == $past(in_vld, 4)));
endmodule

// File: tb/fpa_pipe_add_tb_top.sv
module fpa_pipe_add_tb_top;
   localparam int EW   = 8;
   localparam int FW   = 16;
   localparam int EMAX = (1 << EW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_vld = 1'b0;
   logic          a_sgn = 1'b0, b_sgn = 1'b0;
   logic [EW-1:0] a_exp = '0, b_exp = '0;
   logic [FW-1:0] a_frac = '0, b_frac = '0;
   logic          out_vld, out_sgn;
   logic [EW-1:0] out_exp;
   logic [FW-1:0] out_frac;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;
   bit done  = 1'b0;

   logic [EW+FW:0] exp_q [$];
   int             cyc_q [$];
   string          tag_q [$];

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   fpa_pipe_add #(.EXP_W(EW), .FRAC_W(FW)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld),
      .a_sgn(a_sgn), .a_exp(a_exp), .a_frac(a_frac),
      .b_sgn(b_sgn), .b_exp(b_exp), .b_frac(b_frac),
      .out_vld(out_vld), .out_sgn(out_sgn), .out_exp(out_exp), .out_frac(out_frac));

   // Result computed from the requirements: {sign, exponent, fraction}
   function automatic logic [EW+FW:0] model(input logic sa, input int ea, input int fa,
                                            input logic sb, input int eb, input int fb);
      int bigf, smlf, e, d, sml, sum, lz, fr;
      logic bigs, smls, sg;
      if (ea >= eb) begin
         bigf = fa; bigs = sa; smlf = fb; smls = sb; e = ea; d = ea - eb;
      end else begin
         bigf = fb; bigs = sb; smlf = fa; smls = sa; e = eb; d = eb - ea;
      end
      sml = (d >= FW) ? 0 : (smlf >> d);
      if (bigs == smls) begin
         sum = bigf + sml; sg = bigs;
      end else if (bigf >= sml) begin
         sum = bigf - sml; sg = bigs;
      end else begin
         sum = sml - bigf; sg = smls;
      end
      if (sum == 0) return '0;
      if (sum >= (1 << FW)) begin
         fr = sum >> 1;
         e  = (e == EMAX) ? EMAX : e + 1;
      end else begin
         lz = 0;
         while (sum < (1 << (FW - 1))) begin
            sum = sum << 1;
            lz++;
         end
         fr = sum;
         e  = (e < lz) ? 0 : e - lz;
      end
      return {sg, EW'(e), FW'(fr)};
   endfunction

   task automatic issue(input logic sa, input int ea, input int fa,
                        input logic sb, input int eb, input int fb, input string tag);
      @(negedge clk);
      in_vld = 1'b1;
      a_sgn = sa; a_exp = EW'(ea); a_frac = FW'(fa);
      b_sgn = sb; b_exp = EW'(eb); b_frac = FW'(fb);
      exp_q.push_back(model(sa, ea, fa, sb, eb, fb));
      cyc_q.push_back(cyc);
      tag_q.push_back(tag);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_vld = 1'b0;
      end
   endtask

   // Monitor: scoreboard pop and compare
   always @(negedge clk) begin
      if (rst_n && out_vld) begin
         if (exp_q.size() == 0) begin
            total++; bad++;
            $display("FAIL R1: result with no pending issue, actual=%h expected=none",
                     {out_sgn, out_exp, out_frac});
         end else begin
            logic [EW+FW:0] e;
            int    c;
            string t;
            e = exp_q.pop_front();
            c = cyc_q.pop_front();
            t = tag_q.pop_front();
            total++;
            if ({out_sgn, out_exp, out_frac} !== e) begin
               bad++;
               $display("FAIL %s: actual=%h expected=%h", t, {out_sgn, out_exp, out_frac}, e);
            end
            total++;
            if (cyc - c != 4) begin
               bad++;
               $display("FAIL R1: latency actual=%0d expected=4", cyc - c);
            end
         end
      end
   end

   initial begin
      #400000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9: reset state
      total++;
      if ({out_vld, out_sgn, out_exp, out_frac} !== '0) begin
         bad++;
         $display("FAIL R9: actual=%h expected=0", {out_vld, out_sgn, out_exp, out_frac});
      end
      rst_n = 1'b1;
      idle(2);

      // back-to-back directed cases
      issue(0, 10, 'h8000, 0, 10, 'h8000, "R4 carry");
      issue(0, 12, 'hC000, 0, 10, 'h8000, "R3 align by 2");
      issue(0, 40, 'h8000, 0, 20, 'hFFFF, "R3 far operand dropped");
      issue(0, 20, 'h8000, 0, 35, 'h8000, "R3 shift of 15");
      issue(0, 5, 'hC000, 1, 5, 'h8000, "R5 R6 A larger");
      issue(0, 5, 'h8000, 1, 5, 'hC000, "R5 B larger sign");
      issue(0, 7, 'h9000, 1, 7, 'h9000, "R7 cancel");
      issue(1, 255, 'h8000, 1, 255, 'hC000, "R8 carry at max exponent");
      issue(0, 2, 'h8000, 1, 2, 'h7F00, "R8 exponent floor");
      issue(1, 0, 0, 1, 0, 0, "R7 zero operands");
      issue(0, 20, 'h0001, 0, 0, 0, "R6 deep normalise");
      issue(1, 9, 'h0300, 0, 12, 'hA000, "R5 R3 mixed");
      idle(3);
      issue(0, 255, 'hFFFF, 0, 255, 'hFFFF, "R8 R4 max carry");
      idle(1);

      // random mix with gaps, R2
      for (int i = 0; i < 400; i++) begin
         int ea, eb;
         ea = int'($urandom % 256);
         eb = ($urandom % 4 == 0) ? int'($urandom % 256) : (ea ^ int'($urandom % 8));
         issue(1'($urandom), ea, int'($urandom % 65536),
               1'($urandom), eb, int'($urandom % 65536), "R2 random");
         if ($urandom % 5 == 0) idle(1 + int'($urandom % 3));
      end
      idle(10);

      // R1: all issued pairs drained
      total++;
      if (exp_q.size() != 0) begin
         bad++;
         $display("FAIL R1: pending actual=%0d expected=0", exp_q.size());
      end
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule